// File: doc/BRIEF.md
# Transmit De-Emphasis Code Encoder (Parallel Domain)

This block sits in the slow parallel clock domain just ahead of an 8:1 serializer. Every accepted parallel word carries eight serial bit slots, and slot 0 is the first one sent on the line. For each slot the block works out a signed drive-level code for a two-tap transmit FIR. The code is intended for a segmented current-mode output driver. The delayed tap is not made with a full-rate delay line. Instead the block reshuffles parallel words: the previous word's last-sent bit is kept in a register and takes the place of the "previous bit" for slot 0 of the next word. Every other slot takes its previous bit from the slot just before it in the same word.

Bits map to symbols as 1 → +1 and 0 → −1. Write the total drive as T and the programmable post-tap weight as b. The code then reduces to two cases. When a slot's bit differs from its previous bit (an XOR transition detect), the code is ±T, which is full emphasis. When the bit repeats, the code is ±(T − 2b), which is the de-emphasized level. A parameter adds a second post tap. That tap uses a two-bit-delayed copy of the stream, built the same way from the previous word's last two bits. The weights are sampled on each valid word, so a link can tune b to suit the length of its channel.

Top module: `tx_deemph_enc`

## Requirements
- R1: Slot k of the output (bits [k*CODE_W +: CODE_W], with slot 0 sent first) is computed from in_word[k] as the current bit. The previous bit is in_word[k-1] for k ≥ 1, and for slot 0 it is bit 7 of the last accepted word. A positive code means the slot bit is 1 and a negative code means it is 0.
- R2: When the slot bit differs from its previous bit, the code is +TOTAL for a 1 and −TOTAL for a 0, whatever the weight.
- R3: When the slot bit equals its previous bit, the code is +(TOTAL − 2b) for a 1 and −(TOTAL − 2b) for a 0, where b is the effective post-tap weight.
- R4: A weight value above TOTAL/(2·POST_TAPS) behaves exactly like TOTAL/(2·POST_TAPS). With the defaults, any post_wt above 16 acts as 16.
- R5: The held previous-word bits load only on a cycle with in_valid high. Idle cycles between words leave them unchanged, so the next word's slot 0 still uses the bit from before the gap.
- R6: After reset the held bits are 0, out_valid is 0, and every slot code reads −TOTAL. This lasts until the first valid word has passed through.
- R7: out_valid is in_valid delayed by exactly one clock. The codes for a word appear in that same cycle. On cycles with no valid input the codes keep their last value, and post_wt is ignored.
- R8: With POST_TAPS = 2, post_wt[5:0] is the first post-tap weight b1 and post_wt[11:6] is the second post-tap weight b2, each clamped to TOTAL/4. The code is (T−b1−b2)·s(n) − b1·s(n−1) − b2·s(n−2). For slot 0, s(n−2) comes from bit 6 of the last accepted word, and for slot 1 it comes from bit 7 of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parallel word strobe |
| in_word | input | LANES | Parallel data, bit 0 is the first bit serialized |
| post_wt | input | POST_TAPS*WGT_W | Unsigned post-tap weight(s), tap 1 in the low field |
| out_valid | output | 1 | Strobe aligned with out_codes |
| out_codes | output | LANES*CODE_W | Signed two's-complement drive codes, one per slot |

## Verification
Two things happen on every accepted word in the same cycle. Slot 0 reads the held bit from the previous word, and the held register is overwritten with the new word's last bit. A design that forwards the new value instead of the old one gives wrong slot-0 codes. The bench provokes this with back-to-back valid words in a permuted order over all 256 values, so the word boundary meets every mix of transition and repeat, and it also inserts idle gaps between some words. A bit-serial reference model keeps its own running previous bits across the whole stream and judges every slot code of both a one-tap and a two-tap instance, using weights inside and outside the clamp range.

// File: rtl/tx_deemph_pkg.sv
package tx_deemph_pkg;

  // Highest number of post taps the encoder supports.
  localparam int MAX_POST = 2;

  // Symbol value of a line bit: 1 -> +1, 0 -> -1.
  function automatic int sym_of(input logic b);
    return b ? 1 : -1;
  endfunction

  // Limit a raw unsigned weight to the allowed ceiling.
  function automatic int clamp_wt(input int raw, input int lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // FIR drive level of one slot.
  // bits[0] = current bit, bits[1] = one back, bits[2] = two back.
  function automatic int slot_level(input int total,
                                    input logic [MAX_POST:0] bits,
                                    input int w1,
                                    input int w2);
    int main_w;
    main_w = total - w1 - w2;
    return main_w * sym_of(bits[0]) - w1 * sym_of(bits[1]) - w2 * sym_of(bits[2]);
  endfunction

endpackage

// File: rtl/tx_deemph_history.sv
module tx_deemph_history #(
  parameter int LANES = 8,
  parameter int POST  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES-1:0]      in_word,
  output logic [LANES+POST-1:0] ext_bits,
  output logic [POST-1:0]       held_bits
);

  // Holds the last POST serial bits of the previous accepted word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_bits <= '0;
    end else if (in_valid) begin
      held_bits <= in_word[LANES-1 -: POST];
    end
  end

  // Extended stream: slot k's current bit sits at index k+POST,
  // and its bit d slots earlier sits at index k+POST-d.
  assign ext_bits = {in_word, held_bits};

endmodule

// File: rtl/tx_deemph_lane.sv
module tx_deemph_lane
  import tx_deemph_pkg::*;
#(
  parameter int TOTAL  = 32,
  parameter int POST   = 1,
  parameter int WGT_W  = 6,
  parameter int CODE_W = 7
) (
  input  logic [POST:0]               taps,
  input  logic [POST-1:0][WGT_W-1:0]  wts,
  output logic [CODE_W-1:0]           code,
  output logic                        trans
);

  logic [MAX_POST:0] bits_ext;
  int                w1;
  int                w2;
  int                level;

  always_comb begin
    bits_ext         = '0;
    bits_ext[POST:0] = taps;
    w1               = int'(wts[0]);
    w2               = (POST > 1) ? int'(wts[POST-1]) : 0;
    level            = slot_level(TOTAL, bits_ext, w1, w2);
    code             = CODE_W'(level);
  end

  // Transition between the slot bit and the bit sent just before it.
  assign trans = taps[0] ^ taps[1];

endmodule

// File: rtl/tx_deemph_outreg.sv
module tx_deemph_outreg #(
  parameter int LANES  = 8,
  parameter int CODE_W = 7,
  parameter int TOTAL  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [LANES-1:0][CODE_W-1:0]  lane_codes,
  output logic                          out_valid,
  output logic [LANES*CODE_W-1:0]       out_codes
);

  localparam logic [CODE_W-1:0] IDLE_CODE = CODE_W'(-TOTAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_codes <= {LANES{IDLE_CODE}};
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_codes <= lane_codes;
      end
    end
  end

endmodule

// File: rtl/tx_deemph_enc.sv
module tx_deemph_enc
  import tx_deemph_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int TOTAL     = 32,
  parameter int POST_TAPS = 1,
  parameter int WGT_W     = 6,
  localparam int CODE_W   = $clog2(TOTAL + 1) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [LANES-1:0]            in_word,
  input  logic [POST_TAPS*WGT_W-1:0]  post_wt,
  output logic                        out_valid,
  output logic [LANES*CODE_W-1:0]     out_codes
);

  localparam int WT_LIM = TOTAL / (2 * POST_TAPS);

  // Named internal events for the checker.
  logic [LANES+POST_TAPS-1:0]         ext_bits;
  logic [POST_TAPS-1:0]               held_bits;
  logic [POST_TAPS-1:0][WGT_W-1:0]    wt_eff;
  logic [LANES-1:0]                   lane_trans;
  logic [LANES-1:0][CODE_W-1:0]       lane_codes;

  tx_deemph_history #(
    .LANES (LANES),
    .POST  (POST_TAPS)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .ext_bits  (ext_bits),
    .held_bits (held_bits)
  );

  // Weight clamp, one per post tap.
  for (genvar j = 0; j < POST_TAPS; j++) begin : g_wt
    assign wt_eff[j] = WGT_W'(clamp_wt(int'(post_wt[j*WGT_W +: WGT_W]), WT_LIM));
  end

  // One encoder per serial slot.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [POST_TAPS:0] taps;
    for (genvar d = 0; d <= POST_TAPS; d++) begin : g_tap
      assign taps[d] = ext_bits[k + POST_TAPS - d];
    end
    tx_deemph_lane #(
      .TOTAL  (TOTAL),
      .POST   (POST_TAPS),
      .WGT_W  (WGT_W),
      .CODE_W (CODE_W)
    ) u_lane (
      .taps  (taps),
      .wts   (wt_eff),
      .code  (lane_codes[k]),
      .trans (lane_trans[k])
    );
  end

  tx_deemph_outreg #(
    .LANES  (LANES),
    .CODE_W (CODE_W),
    .TOTAL  (TOTAL)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .lane_codes (lane_codes),
    .out_valid  (out_valid),
    .out_codes  (out_codes)
  );

endmodule

// File: rtl/tx_deemph_checks.sv
module tx_deemph_checks #(
  parameter int LANES     = 8,
  parameter int TOTAL     = 32,
  parameter int POST_TAPS = 1,
  parameter int WGT_W     = 6,
  parameter int CODE_W    = 7
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              in_valid,
  input logic [LANES-1:0]                  in_word,
  input logic                              out_valid,
  input logic [LANES*CODE_W-1:0]           out_codes,
  input logic [POST_TAPS-1:0]              held_bits,
  input logic [LANES-1:0]                  lane_trans,
  input logic [POST_TAPS-1:0][WGT_W-1:0]   wt_eff
);

  localparam logic [CODE_W-1:0] POS_FULL = CODE_W'(TOTAL);
  localparam logic [CODE_W-1:0] NEG_FULL = CODE_W'(-TOTAL);
  localparam int                WT_LIM   = TOTAL / (2 * POST_TAPS);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (out_valid) seen <= 1'b1;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_codes)); // R7
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(held_bits)); // R5
  AST_HELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> held_bits == $past(in_word[LANES-1 -: POST_TAPS])); // R5
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !out_valid) |-> out_codes == {LANES{NEG_FULL}}); // R6

  for (genvar j = 0; j < POST_TAPS; j++) begin : g_wchk
    AST_WT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wt_eff[j]) <= WT_LIM); // R4
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lchk
    if (POST_TAPS == 1) begin : g_one
      AST_TRANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_trans[k])) |->
          (out_codes[k*CODE_W +: CODE_W] == POS_FULL ||
           out_codes[k*CODE_W +: CODE_W] == NEG_FULL)); // R2
    end
    AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $signed(out_codes[k*CODE_W +: CODE_W]) > 0) |->
        $past(in_word[k])); // R1
    AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $signed(out_codes[k*CODE_W +: CODE_W]) < 0) |->
        !$past(in_word[k])); // R1
  end

endmodule

bind tx_deemph_enc tx_deemph_checks #(
  .LANES     (LANES),
  .TOTAL     (TOTAL),
  .POST_TAPS (POST_TAPS),
  .WGT_W     (WGT_W),
  .CODE_W    (CODE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_codes  (out_codes),
  .held_bits  (held_bits),
  .lane_trans (lane_trans),
  .wt_eff     (wt_eff)
);

// File: tb/tb_tx_deemph_enc.sv
module tb_tx_deemph_enc;

  localparam int T  = 32;
  localparam int CW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_word = '0;
  logic [5:0]  wt_a = '0;
  logic [5:0]  wt_b = '0;
  logic        ov1, ov2;
  logic [8*CW-1:0] oc1, oc2;

  int total_n = 0;
  int bad_n   = 0;

  // Bench-side reference state.
  logic sp1 = 1'b0, sp2 = 1'b0;
  int   exp1 [8];
  int   exp2 [8];
  logic expv = 1'b0;
  string tag1 = "R6";
  string tag2 = "R6";

  always #2 clk = ~clk; // 250 MHz

  tx_deemph_enc #(.LANES(8), .TOTAL(T), .POST_TAPS(1), .WGT_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .post_wt(wt_a), .out_valid(ov1), .out_codes(oc1));

  tx_deemph_enc #(.LANES(8), .TOTAL(T), .POST_TAPS(2), .WGT_W(6)) dut2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .post_wt({wt_b, wt_a}), .out_valid(ov2), .out_codes(oc2));

  function automatic int s_of(input logic b);
    return b ? 1 : -1;
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic compare(input string tag, input logic ov, input logic [8*CW-1:0] oc,
                         input int ex [8]);
    int got;
    logic ok;
    ok = 1'b1;
    total_n++;
    if (ov !== expv) begin
      ok = 1'b0;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, ov, expv);
    end
    for (int k = 0; k < 8; k++) begin
      got = int'($signed(oc[k*CW +: CW]));
      if (ok && got != ex[k]) begin
        ok = 1'b0;
        $display("FAIL %s slot %0d actual=%0d expected=%0d", tag, k, got, ex[k]);
      end
    end
    if (!ok) bad_n++;
  endtask

  // Check what the previous step produced, then drive the next step.
  task automatic step(input logic v, input logic [7:0] w, input int a, input int b,
                      input string tg);
    int c1, c2a, c2b;
    logic cur;
    @(negedge clk);
    compare(tag1, ov1, oc1, exp1);
    compare(tag2, ov2, oc2, exp2);
    in_valid = v;
    in_word  = w;
    wt_a     = 6'(a);
    wt_b     = 6'(b);
    expv     = v;
    if (v) begin
      c1  = mn(a, T/2);   // R4 clamp for one tap
      c2a = mn(a, T/4);   // R8 clamps for two taps
      c2b = mn(b, T/4);
      for (int k = 0; k < 8; k++) begin
        cur = w[k];
        // One tap: transition -> full, repeat -> full minus twice the weight (R2, R3)
        exp1[k] = (cur != sp1) ? T * s_of(cur) : (T - 2*c1) * s_of(cur);
        exp2[k] = (T - c2a - c2b) * s_of(cur) - c2a * s_of(sp1) - c2b * s_of(sp2);
        sp2 = sp1;
        sp1 = cur;
      end
      tag1 = tg;
      tag2 = "R8";
    end else begin
      tag1 = "R7";
      tag2 = "R7";
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      exp1[k] = -T;
      exp2[k] = -T;
    end
    #(4 * 200000);
    bad_n++;
    total_n++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    int wa [4];
    int wb [4];
    wa = '{0, 5, 16, 40};
    wb = '{0, 3, 8, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: idle codes and no valid until the first word.
    tag1 = "R6";
    tag2 = "R6";
    step(1'b0, 8'h00, 0, 0, "R6");
    tag1 = "R6";
    tag2 = "R6";
    step(1'b0, 8'hFF, 10, 10, "R6");
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < 256; w++) begin
        logic [7:0] word;
        word = 8'((w * 37 + p * 11) & 255);
        step(1'b1, word, wa[p], wb[p], (wa[p] > T/2) ? "R4" : "R1 R2 R3 R5");
        if (w % 7 == 6) begin
          // R5/R7: gap with weights changed; must have no effect.
          step(1'b0, ~word, 63 - wa[p], 1, "R7");
        end
      end
    end
    step(1'b0, 8'h00, 0, 0, "R7");
    step(1'b0, 8'h00, 0, 0, "R7");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

endmodule